// File: doc/BRIEF.md
# Dual 16-bit Signed Multiply-Accumulate Unit

This datapath takes two 32-bit operands, N and M. Each operand holds a pair of signed 16-bit halfwords. The unit multiplies the low halves together and the high halves together. It then adds the two products or subtracts the second from the first. It can optionally add a 32-bit accumulator value to that combination. Before the multiplies, the halves of M can be exchanged, which is the same as rotating M right by 16 bits. Together these controls give four operation forms: dual multiply-add and dual multiply-subtract, each with or without the accumulate step.

The result is always the wrapped 32-bit two's-complement value. The unit never saturates. Signed 32-bit overflow at a checked addition sets a sticky flag. The flag stays set until an explicit clear is applied. The host drives one operation per `in_valid` pulse. The result and its valid strobe appear one clock later.

Top module: `dual_mac`

## Requirements
- R1: When `swap_m` is 1, the upper and lower 16-bit halves of `op_m` are exchanged before multiplication. When it is 0, `op_m` is used as given.
- R2: Each halfword is signed. p1 is N[15:0]×M'[15:0] and p2 is N[31:16]×M'[31:16], where M' is M after the optional swap. With `sub_sel`=0 the combination is p1+p2.
- R3: With `sub_sel`=1 the combination is p1−p2.
- R4: With `acc_en`=1, `acc_in` is added to the combination. With `acc_en`=0, `acc_in` has no effect.
- R5: In the add forms (`sub_sel`=0), the flag `q_flag` is set when p1+p2 overflows as a signed 32-bit addition. Both products equal to (−32768)×(−32768) is such a case.
- R6: In the accumulating add form, `q_flag` is also set when (p1+p2)+`acc_in` overflows as a signed 32-bit addition.
- R7: In the subtract forms, the difference p1−p2 is never flagged. Only the step (p1−p2)+`acc_in` is checked for overflow, and only when `acc_en`=1.
- R8: `res_out` is the wrapped 32-bit two's-complement result and is never saturated.
- R9: `q_flag` is sticky. Later operations without overflow leave it set. A `q_clr` pulse clears it. When a clear and a new overflow fall in the same cycle, the flag ends up set.
- R10: `res_valid` and `res_out` follow `in_valid` by one clock, and the `q_flag` update lands on the same edge. Without `in_valid`, `res_out` holds its value and `res_valid` is 0.
- R11: After reset, `res_out` is 0, `res_valid` is 0 and `q_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| op_n | input | 32 | Packed signed halfword pair N |
| op_m | input | 32 | Packed signed halfword pair M |
| acc_in | input | 32 | Accumulator addend |
| swap_m | input | 1 | Exchange the halves of M |
| sub_sel | input | 1 | 0: p1+p2, 1: p1−p2 |
| acc_en | input | 1 | Add `acc_in` to the combination |
| q_clr | input | 1 | Clear the sticky overflow flag |
| res_out | output | 32 | Registered result |
| res_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| q_flag | output | 1 | Sticky overflow flag |

## Verification
Every internal fault in this block reaches the ports on the edge after the offending operation. A wrong halfword pairing, sign extension or swap shows as a wrong `res_out` exactly one cycle after `in_valid`. A misplaced overflow check shows as a wrong `q_flag` on that same edge. Because the flag is sticky, a spurious set stays visible until the next clear. A flag that fails to hold is exposed by a following operation that does not overflow.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  parameter int HALF_W = 16;
  parameter int DATA_W = 2 * HALF_W;

  // signed overflow of a + b: equal input signs, result sign differs from a
  function automatic logic add_ovf(input logic [DATA_W-1:0] a,
                                   input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] s;
    s = a + b;
    return (a[DATA_W-1] == b[DATA_W-1]) && (s[DATA_W-1] != a[DATA_W-1]);
  endfunction

  // sign-extended halfword product, kept at full data width
  function automatic logic [DATA_W-1:0] half_mul(input logic [HALF_W-1:0] x,
                                                 input logic [HALF_W-1:0] y);
    logic signed [DATA_W-1:0] xe;
    logic signed [DATA_W-1:0] ye;
    xe = {{HALF_W{x[HALF_W-1]}}, x};
    ye = {{HALF_W{y[HALF_W-1]}}, y};
    return xe * ye;
  endfunction
endpackage

// File: rtl/dmac_swap.sv
module dmac_swap
  import dmac_pkg::*;
(
  input  logic [DATA_W-1:0] m_in,
  input  logic              swap,
  output logic [DATA_W-1:0] m_out
);
  logic [DATA_W-1:0] rotated;
  assign rotated = {m_in[HALF_W-1:0], m_in[DATA_W-1:HALF_W]};
  assign m_out   = swap ? rotated : m_in;

  always_comb begin
    AST_SWAP_HALVES: assert (!swap || (m_out[HALF_W-1:0] == m_in[DATA_W-1:HALF_W])); // R1
  end
endmodule

// File: rtl/dmac_mul.sv
module dmac_mul
  import dmac_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [DATA_W-1:0] n_in,
  input  logic [DATA_W-1:0] m_in,
  output logic [DATA_W-1:0] prod [LANES]
);
  localparam int PACK_W = LANES * HALF_W;
  logic [PACK_W-1:0] n_pk;
  logic [PACK_W-1:0] m_pk;
  assign n_pk = n_in[PACK_W-1:0];
  assign m_pk = m_in[PACK_W-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign prod[g] = half_mul(n_pk[g*HALF_W +: HALF_W], m_pk[g*HALF_W +: HALF_W]);
  end
endmodule

// File: rtl/dmac_comb.sv
module dmac_comb
  import dmac_pkg::*;
(
  input  logic [DATA_W-1:0] p1,
  input  logic [DATA_W-1:0] p2,
  input  logic [DATA_W-1:0] acc,
  input  logic              sub_sel,
  input  logic              acc_en,
  output logic [DATA_W-1:0] total,
  output logic              ovf_pair,
  output logic              ovf_acc
);
  logic [DATA_W-1:0] mid;
  logic [DATA_W-1:0] addend;

  assign mid      = sub_sel ? (p1 - p2) : (p1 + p2);
  assign addend   = acc_en ? acc : '0;
  assign total    = mid + addend;
  assign ovf_pair = !sub_sel && add_ovf(p1, p2);
  assign ovf_acc  = acc_en && add_ovf(mid, acc);

  always_comb begin
    AST_NO_ACC_NO_ACC_FLAG: assert (acc_en || !ovf_acc); // R7
    AST_PLAIN_PASS: assert (acc_en || (total == mid)); // R4
  end
endmodule

// File: rtl/dual_mac.sv
module dual_mac
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_n,
  input  logic [DATA_W-1:0] op_m,
  input  logic [DATA_W-1:0] acc_in,
  input  logic              swap_m,
  input  logic              sub_sel,
  input  logic              acc_en,
  input  logic              q_clr,
  output logic [DATA_W-1:0] res_out,
  output logic              res_valid,
  output logic              q_flag
);
  localparam int LANES = DATA_W / HALF_W;

  logic [DATA_W-1:0] m_eff;
  logic [DATA_W-1:0] prod [LANES];
  logic [DATA_W-1:0] total;
  logic              ovf_pair;
  logic              ovf_acc;
  logic              ovf_event;

  dmac_swap u_swap (
    .m_in  (op_m),
    .swap  (swap_m),
    .m_out (m_eff)
  );

  dmac_mul #(.LANES(LANES)) u_mul (
    .n_in (op_n),
    .m_in (m_eff),
    .prod (prod)
  );

  dmac_comb u_comb (
    .p1       (prod[0]),
    .p2       (prod[1]),
    .acc      (acc_in),
    .sub_sel  (sub_sel),
    .acc_en   (acc_en),
    .total    (total),
    .ovf_pair (ovf_pair),
    .ovf_acc  (ovf_acc)
  );

  assign ovf_event = in_valid && (ovf_pair || ovf_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_out   <= '0;
      res_valid <= 1'b0;
      q_flag    <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_out <= total;
      q_flag <= (q_flag && !q_clr) || ovf_event;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> res_valid); // R10
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(res_out)); // R10
  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (q_flag && !q_clr) |=> q_flag); // R9
  AST_Q_SET: assert property (@(posedge clk) disable iff (!rst_n) ovf_event |=> q_flag); // R5
  AST_Q_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(q_flag) |-> $past(in_valid)); // R6
endmodule

// File: tb/tb_dual_mac.sv
module tb_dual_mac;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_n = '0;
  logic [31:0] op_m = '0;
  logic [31:0] acc_in = '0;
  logic        swap_m = 1'b0;
  logic        sub_sel = 1'b0;
  logic        acc_en = 1'b0;
  logic        q_clr = 1'b0;
  logic [31:0] res_out;
  logic        res_valid;
  logic        q_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_mac dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_n(op_n), .op_m(op_m),
    .acc_in(acc_in), .swap_m(swap_m), .sub_sel(sub_sel), .acc_en(acc_en),
    .q_clr(q_clr), .res_out(res_out), .res_valid(res_valid), .q_flag(q_flag)
  );

  // fields: n | m | acc | swap | sub | acc_en | expected result | expected flag
  localparam int VW = 132;
  localparam int NV = 13;
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h0003_0002, 32'h0005_0004, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0017, 1'b0}, // R2
    {32'h0003_0002, 32'h0005_0004, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 32'h0000_0016, 1'b0}, // R1
    {32'h0003_0002, 32'h0005_0004, 32'h1234_5678, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFF9, 1'b0}, // R3 R4
    {32'hFFFF_FFFE, 32'h0007_0003, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFF3, 1'b0}, // R2
    {32'h0003_0002, 32'h0005_0004, 32'h0000_0064, 1'b0, 1'b0, 1'b1, 32'h0000_007B, 1'b0}, // R4
    {32'h0003_0002, 32'h0005_0004, 32'h0000_0064, 1'b0, 1'b1, 1'b1, 32'h0000_005D, 1'b0}, // R4
    {32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b1}, // R5 R8
    {32'h8000_8000, 32'h8000_8000, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 32'h0000_0000, 1'b0}, // R7
    {32'h7FFF_8000, 32'h8000_8000, 32'h0001_0000, 1'b0, 1'b1, 1'b1, 32'h8000_8000, 1'b1}, // R7 R8
    {32'h4000_4000, 32'h0002_0002, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h8000_FFFF, 1'b1}, // R6
    {32'h8000_8000, 32'h7FFF_7FFF, 32'h8000_0000, 1'b0, 1'b0, 1'b1, 32'h0001_0000, 1'b1}, // R6
    {32'h8000_8000, 32'h8000_8000, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h7FFF_FFFF, 1'b1}, // R5 R9
    {32'h0001_0010, 32'h0003_0002, 32'h0000_0000, 1'b1, 1'b1, 1'b0, 32'h0000_002E, 1'b0}  // R1 R3
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge (one rising edge between)
  task automatic issue(input logic [31:0] n, input logic [31:0] m, input logic [31:0] a,
                       input logic sw, input logic sb, input logic ae, input logic clr);
    @(negedge clk);
    op_n = n; op_m = m; acc_in = a; swap_m = sw; sub_sel = sb; acc_en = ae;
    q_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; q_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 res_out", res_out, 32'h0);
    check("R11 res_valid", {31'b0, res_valid}, 32'h0);
    check("R11 q_flag", {31'b0, q_flag}, 32'h0);
    rst_n = 1'b1;

    // table walk: each vector clears the flag in its own cycle, so q_flag equals its own overflow
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][131:100], VEC[i][99:68], VEC[i][67:36],
            VEC[i][35], VEC[i][34], VEC[i][33], 1'b1);
      check($sformatf("R2/R3/R4/R8 vec%0d result", i), res_out, VEC[i][32:1]);
      check($sformatf("R5/R6/R7 vec%0d flag", i), {31'b0, q_flag}, {31'b0, VEC[i][0]});
      check($sformatf("R10 vec%0d valid", i), {31'b0, res_valid}, 32'h1);
    end

    // R10: no strobe -> valid drops, result holds
    @(negedge clk);
    check("R10 valid low", {31'b0, res_valid}, 32'h0);
    check("R10 hold", res_out, 32'h0000_002E);

    // R9: set flag, then a non-overflowing op without clear keeps it set
    issue(32'h8000_8000, 32'h8000_8000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R5 corner flag", {31'b0, q_flag}, 32'h1);
    issue(32'h0003_0002, 32'h0005_0004, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 sticky", {31'b0, q_flag}, 32'h1);
    check("R9 result", res_out, 32'h0000_0017);

    // R9: clear alone, no strobe
    @(negedge clk);
    q_clr = 1'b1;
    @(negedge clk);
    q_clr = 1'b0;
    check("R9 clear", {31'b0, q_flag}, 32'h0);
    check("R10 hold after clear", res_out, 32'h0000_0017);

    // R7: maximal difference without accumulate is never flagged
    issue(32'h7FFF_8000, 32'h8000_8000, 32'h7FFF_FFFF, 1'b0, 1'b1, 1'b0, 1'b0);
    check("R7 diff unflagged", {31'b0, q_flag}, 32'h0);
    check("R7 diff value", res_out, 32'h7FFF_8000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule